// File: doc/BRIEF.md
# Video/CPU DRAM slot sequencer

This block produces the strobes for one DRAM that a video fetch engine and a CPU share. It runs from a 16 MHz master clock. Every 1 µs it walks a fixed 16-phase frame. Early in the frame it opens one row and strobes the column twice, which reads two video bytes in page mode. Later in the frame it opens a second row with the address mux turned to the CPU side. The column strobe for that second row is issued only when the CPU asked for memory and the cycle is not a refresh. Once per frame, at a fixed phase, the block pulls READY low. It does this without looking at the CPU's activity: a CPU that is not on the bus ignores the wait. The block also supplies the 4 MHz CPU clock and a one-cycle frame-start marker.

A phase counter drives a slot state machine. The states and their order are:
- `ST_PRECHARGE` (phases 14, 15, 0, 1), which moves to `ST_VID_ROW` at the end of phase 1.
- `ST_VID_ROW` (phase 2), then `ST_VID_COL0` (3), then `ST_VID_GAP` (4), then `ST_VID_COL1` (5), then `ST_VID_HOLD` (6). Each of these moves on after one cycle.
- `ST_MID_IDLE` (phases 7 to 9), which moves to `ST_CPU_ROW` at the end of phase 9.
- `ST_CPU_ROW` (10, 11), which moves to `ST_CPU_COL` at the end of phase 11. The CPU request is captured on that transition.
- `ST_CPU_COL` (12, 13), which returns to `ST_PRECHARGE` at the end of phase 13.

Reset forces `ST_PRECHARGE` and phase 0.

Top module: `dram_slot_sequencer`

## Requirements
- R1: A frame lasts exactly 16 master clocks. `frame_start` is high only in phase 0, and the phase advances by one on each clock.
- R2: The reset input is synchronous and active high. While it is held, and in the first cycle after it is applied, the outputs show phase 0: ras_n=1, cas_n=1, cpu_sel=0, ready=1, cpu_clk=0, frame_start=1. Reset also clears any captured CPU grant.
- R3: Video slot: ras_n is low in phases 2 to 6, and cas_n is low in phases 3 and 5 only, while cpu_sel=0.
- R4: cpu_sel is 1 exactly in phases 10 to 13 (1 MHz, 25% duty), and ras_n is low in those same phases.
- R5: cas_n is low in phases 12 and 13 only when, at the clock edge that ends phase 11, mreq_n=0 and refresh_n=1. Otherwise cas_n stays high in those phases.
- R6: Values of mreq_n and refresh_n in any phase other than 11 have no effect on any output.
- R7: ready is 0 in phases 4 to 7 and 1 in all other phases, whatever the CPU inputs are.
- R8: cpu_clk is 1 in the phases whose value modulo 4 is 2 or 3, giving a 4 MHz clock with 50% duty.
- R9: cas_n is never low while ras_n is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 16 MHz master clock |
| rst | input | 1 | Synchronous reset, active high |
| mreq_n | input | 1 | CPU memory request, active low |
| refresh_n | input | 1 | CPU refresh indication, active low |
| ras_n | output | 1 | DRAM row strobe, active low |
| cas_n | output | 1 | DRAM column strobe, active low |
| cpu_sel | output | 1 | Address mux select, 1 selects the CPU address |
| ready | output | 1 | CPU ready, 0 inserts a wait |
| cpu_clk | output | 1 | CPU clock, master clock divided by 4 |
| frame_start | output | 1 | High during phase 0 of each frame |

## Verification
The bench runs whole frames, each with three separate input settings: one for phases 0 to 10, one for phase 11, and one for phases 12 to 15. Some settings request memory only in phase 11 and some only outside it, which shows that the grant follows the phase-11 sample alone. A refresh paired with a memory request is included, which shows that the CPU column strobe is gated off. Patterns that change right after the sample confirm that the strobe stays fixed during the CPU column slot. A reset applied in the middle of the wait window shows that the frame restarts cleanly from phase 0.

// File: rtl/dram_slot_pkg.sv
package dram_slot_pkg;

    localparam int PHASE_W = 4;
    typedef logic [PHASE_W-1:0] phase_t;

    // Frame schedule: the state machine leaves each slot at its last phase.
    localparam phase_t PH_PRE_LAST    = phase_t'(1);
    localparam phase_t PH_VROW        = phase_t'(2);
    localparam phase_t PH_VCOL0       = phase_t'(3);
    localparam phase_t PH_VGAP        = phase_t'(4);
    localparam phase_t PH_VCOL1       = phase_t'(5);
    localparam phase_t PH_VHOLD       = phase_t'(6);
    localparam phase_t PH_MID_LAST    = phase_t'(9);
    localparam phase_t PH_CROW_LAST   = phase_t'(11);
    localparam phase_t PH_CCOL_LAST   = phase_t'(13);

    // Wait window driven on the ready output.
    localparam phase_t PH_WAIT_FIRST  = phase_t'(4);
    localparam phase_t PH_WAIT_LAST   = phase_t'(7);

    // CPU clock = master / 2**CPU_DIV_LOG2.
    localparam int CPU_DIV_LOG2 = 2;

    typedef enum logic [3:0] {
        ST_PRECHARGE,
        ST_VID_ROW,
        ST_VID_COL0,
        ST_VID_GAP,
        ST_VID_COL1,
        ST_VID_HOLD,
        ST_MID_IDLE,
        ST_CPU_ROW,
        ST_CPU_COL
    } slot_e;

endpackage

// File: rtl/dram_phase_ctr.sv
module dram_phase_ctr #(
    parameter int W = dram_slot_pkg::PHASE_W
) (
    input  logic         clk,
    input  logic         rst,
    output logic [W-1:0] phase,
    output logic         frame_start
);

    logic [W-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    assign phase       = phase_q;
    assign frame_start = (phase_q == '0);

endmodule

// File: rtl/dram_slot_fsm.sv
module dram_slot_fsm
    import dram_slot_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  phase_t phase,
    input  logic   cpu_req,
    output slot_e  state,
    output logic   cpu_go
);

    slot_e state_q;
    slot_e state_d;
    logic  go_q;

    // Next-state logic: each slot ends on a fixed phase.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PRECHARGE: if (phase == PH_PRE_LAST)  state_d = ST_VID_ROW;
            ST_VID_ROW:   if (phase == PH_VROW)      state_d = ST_VID_COL0;
            ST_VID_COL0:  if (phase == PH_VCOL0)     state_d = ST_VID_GAP;
            ST_VID_GAP:   if (phase == PH_VGAP)      state_d = ST_VID_COL1;
            ST_VID_COL1:  if (phase == PH_VCOL1)     state_d = ST_VID_HOLD;
            ST_VID_HOLD:  if (phase == PH_VHOLD)     state_d = ST_MID_IDLE;
            ST_MID_IDLE:  if (phase == PH_MID_LAST)  state_d = ST_CPU_ROW;
            ST_CPU_ROW:   if (phase == PH_CROW_LAST) state_d = ST_CPU_COL;
            ST_CPU_COL:   if (phase == PH_CCOL_LAST) state_d = ST_PRECHARGE;
            default:                                 state_d = ST_PRECHARGE;
        endcase
    end

    // State register with the CPU grant captured on entry to the column slot.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_PRECHARGE;
            go_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_CPU_ROW && state_d == ST_CPU_COL) begin
                go_q <= cpu_req;
            end
        end
    end

    assign state  = state_q;
    assign cpu_go = go_q;

endmodule

// File: rtl/dram_strobe_gen.sv
module dram_strobe_gen
    import dram_slot_pkg::*;
(
    input  slot_e  state,
    input  logic   cpu_go,
    input  phase_t phase,
    output logic   ras_n,
    output logic   cas_n,
    output logic   cpu_sel,
    output logic   ready,
    output logic   cpu_clk
);

    // Strobe outputs from the slot state.
    always_comb begin
        ras_n   = 1'b1;
        cas_n   = 1'b1;
        cpu_sel = 1'b0;
        unique case (state)
            ST_PRECHARGE: ;
            ST_VID_ROW:   ras_n = 1'b0;
            ST_VID_COL0:  begin ras_n = 1'b0; cas_n = 1'b0; end
            ST_VID_GAP:   ras_n = 1'b0;
            ST_VID_COL1:  begin ras_n = 1'b0; cas_n = 1'b0; end
            ST_VID_HOLD:  ras_n = 1'b0;
            ST_MID_IDLE:  ;
            ST_CPU_ROW:   begin ras_n = 1'b0; cpu_sel = 1'b1; end
            ST_CPU_COL:   begin ras_n = 1'b0; cpu_sel = 1'b1; cas_n = ~cpu_go; end
            default:      ;
        endcase
    end

    // Wait window and CPU clock follow the phase alone.
    assign ready   = ~((phase >= PH_WAIT_FIRST) && (phase <= PH_WAIT_LAST));
    assign cpu_clk = phase[CPU_DIV_LOG2-1];

endmodule

// File: rtl/dram_slot_sequencer.sv
module dram_slot_sequencer
    import dram_slot_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic mreq_n,
    input  logic refresh_n,
    output logic ras_n,
    output logic cas_n,
    output logic cpu_sel,
    output logic ready,
    output logic cpu_clk,
    output logic frame_start
);

    phase_t phase;
    slot_e  state;
    logic   cpu_go;
    logic   cpu_req;

    assign cpu_req = ~mreq_n & refresh_n;

    dram_phase_ctr #(.W(PHASE_W)) i_ctr (
        .clk         (clk),
        .rst         (rst),
        .phase       (phase),
        .frame_start (frame_start)
    );

    dram_slot_fsm i_fsm (
        .clk     (clk),
        .rst     (rst),
        .phase   (phase),
        .cpu_req (cpu_req),
        .state   (state),
        .cpu_go  (cpu_go)
    );

    dram_strobe_gen i_gen (
        .state   (state),
        .cpu_go  (cpu_go),
        .phase   (phase),
        .ras_n   (ras_n),
        .cas_n   (cas_n),
        .cpu_sel (cpu_sel),
        .ready   (ready),
        .cpu_clk (cpu_clk)
    );

endmodule

// File: rtl/dram_slot_sequencer_chk.sv
module dram_slot_sequencer_chk
    import dram_slot_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic mreq_n,
    input logic refresh_n,
    input logic ras_n,
    input logic cas_n,
    input logic cpu_sel,
    input logic ready,
    input logic cpu_clk,
    input logic frame_start
);

    phase_t ref_cnt;

    always_ff @(posedge clk) begin
        if (rst) ref_cnt <= '0;
        else     ref_cnt <= ref_cnt + 1'b1;
    end

    p_frame_mark_r1: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> (ref_cnt == '0));
    p_frame_due_r1: assert property (@(posedge clk) disable iff (rst)
        (ref_cnt == '0) |-> frame_start);

    p_cas_in_row_r9: assert property (@(posedge clk) disable iff (rst)
        !cas_n |-> !ras_n);

    p_cpu_row_open_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(cpu_sel) |-> $fell(ras_n));
    p_cpu_row_close_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(cpu_sel) |-> $rose(ras_n));

    p_cpu_cas_granted_r5: assert property (@(posedge clk) disable iff (rst)
        ($fell(cas_n) && cpu_sel) |-> $past(!mreq_n && refresh_n));

    p_wait_phase_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(ready) |-> $past(frame_start, 4));
    p_wait_hold_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(ready) |=> !ready);

    p_clk_high_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(cpu_clk) |=> cpu_clk);
    p_clk_low_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(cpu_clk) |=> !cpu_clk);

endmodule

bind dram_slot_sequencer dram_slot_sequencer_chk i_chk (
    .clk         (clk),
    .rst         (rst),
    .mreq_n      (mreq_n),
    .refresh_n   (refresh_n),
    .ras_n       (ras_n),
    .cas_n       (cas_n),
    .cpu_sel     (cpu_sel),
    .ready       (ready),
    .cpu_clk     (cpu_clk),
    .frame_start (frame_start)
);

// File: tb/test_dram_slot_sequencer.sv
module test_dram_slot_sequencer;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mreq_n = 1'b1;
    logic refresh_n = 1'b1;
    logic ras_n, cas_n, cpu_sel, ready, cpu_clk, frame_start;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dram_slot_sequencer i_dram_slot_sequencer (
        .clk         (clk),
        .rst         (rst),
        .mreq_n      (mreq_n),
        .refresh_n   (refresh_n),
        .ras_n       (ras_n),
        .cas_n       (cas_n),
        .cpu_sel     (cpu_sel),
        .ready       (ready),
        .cpu_clk     (cpu_clk),
        .frame_start (frame_start)
    );

    // Vector: [5:4] phases 0-10, [3:2] phase 11, [1:0] phases 12-15; each {mreq_n, refresh_n}.
    localparam int NVEC = 8;
    localparam logic [5:0] VEC [NVEC] = '{
        6'b11_01_11,
        6'b01_01_01,
        6'b01_11_01,
        6'b01_00_01,
        6'b11_11_11,
        6'b00_10_00,
        6'b11_01_10,
        6'b01_01_11
    };

    task automatic chk(string req, string what, logic act, logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic check_phase(int ph, logic go, string cpu_tag);
        logic e_ras, e_cas, e_sel, e_rdy, e_clk, e_fs;
        e_ras = !((ph >= 2 && ph <= 6) || (ph >= 10 && ph <= 13));
        e_cas = !(ph == 3 || ph == 5 || ((ph == 12 || ph == 13) && go));
        e_sel = (ph >= 10 && ph <= 13);
        e_rdy = !(ph >= 4 && ph <= 7);
        e_clk = ((ph % 4) >= 2);
        e_fs  = (ph == 0);
        chk("R1", "frame_start", frame_start, e_fs);
        chk("R3", "ras_n", ras_n, e_ras);
        chk((ph >= 12 && ph <= 13) ? cpu_tag : "R3", "cas_n", cas_n, e_cas);
        chk("R4", "cpu_sel", cpu_sel, e_sel);
        chk("R7", "ready", ready, e_rdy);
        chk("R8", "cpu_clk", cpu_clk, e_clk);
        chk("R9", "cas_inside_ras", !(ras_n && !cas_n), 1'b1);
    endtask

    // Starts at a negedge showing phase 0, ends at the next phase 0.
    task automatic run_frame(logic [1:0] a, logic [1:0] b, logic [1:0] c, string cpu_tag);
        logic go;
        go = (b == 2'b01);
        for (int ph = 0; ph < 16; ph++) begin
            check_phase(ph, go, cpu_tag);
            if (ph < 11)       {mreq_n, refresh_n} = a;
            else if (ph == 11) {mreq_n, refresh_n} = b;
            else               {mreq_n, refresh_n} = c;
            @(negedge clk);
        end
    endtask

    task automatic check_reset_view();
        chk("R2", "ras_n", ras_n, 1'b1);
        chk("R2", "cas_n", cas_n, 1'b1);
        chk("R2", "cpu_sel", cpu_sel, 1'b0);
        chk("R2", "ready", ready, 1'b1);
        chk("R2", "cpu_clk", cpu_clk, 1'b0);
        chk("R2", "frame_start", frame_start, 1'b1);
    endtask

    initial begin
        rst = 1'b1;
        mreq_n = 1'b0;
        refresh_n = 1'b1;
        repeat (2) @(negedge clk);
        check_reset_view();              // R2 while held
        @(negedge clk);
        check_reset_view();
        rst = 1'b0;

        // Vector walk: R5 grant sample, R6 insensitivity outside phase 11.
        for (int i = 0; i < NVEC; i++) begin
            run_frame(VEC[i][5:4], VEC[i][3:2], VEC[i][1:0], "R5/R6");
        end

        // R2: reset in the middle of the wait window returns to phase 0.
        mreq_n = 1'b1;
        refresh_n = 1'b1;
        for (int ph = 0; ph < 7; ph++) @(negedge clk);
        chk("R7", "ready_before_reset", ready, 1'b0);
        rst = 1'b1;
        @(negedge clk);
        check_reset_view();
        rst = 1'b0;
        run_frame(2'b11, 2'b01, 2'b11, "R5");

        // R2: reset during a granted CPU column clears the grant.
        for (int ph = 0; ph < 11; ph++) begin
            {mreq_n, refresh_n} = 2'b01;
            @(negedge clk);
        end
        @(negedge clk);                  // phase 12, grant taken
        chk("R5", "cas_n_granted", cas_n, 1'b0);
        rst = 1'b1;
        {mreq_n, refresh_n} = 2'b11;
        @(negedge clk);
        check_reset_view();
        rst = 1'b0;
        run_frame(2'b01, 2'b11, 2'b01, "R2");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule